// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from the core clock. Software supplies an 11-bit divider value that holds the wanted divisor minus two, so the card clock runs at core/(value+2). Two divisors come from that one value. In identification mode all 11 bits count. In data mode only the three low bits count, which gives the fast divisors 2 to 9. The block moves between them by itself when the controller's mode indication changes. A slow-card configuration bit pins the block to the full 11-bit divisor in every mode.

Besides the card clock, the block emits two core-domain strobes, each one core cycle wide. One marks the cycle in which the card clock goes high and the other the cycle in which it goes low. Logic that shifts command and data bits can use them as clock enables.

A new divider value or mode is taken up only at the next card-clock rising edge. A period that has started always finishes with its old high and low lengths, so no runt pulse can appear.

The core is a two-state machine. In `PH_HIGH` the card clock is high and in `PH_LOW` it is low. A down-counter sets how long each state lasts. The machine has two transitions:
- `LOW->HIGH` fires when the counter expires in `PH_LOW`. It latches the divisor the selector offers, loads the high-phase length and raises the rise strobe.
- `HIGH->LOW` fires when the counter expires in `PH_HIGH`. It loads the low-phase length of the latched divisor and raises the fall strobe.

Reset leaves the machine in `PH_LOW` with an expired counter.

Top module: `sdclk_gen`

## Requirements
- R1: With `data_mode`=0, a divider value V gives a card-clock period of exactly V+2 core cycles for every V from 0 to 2047.
- R2: With `data_mode`=1 and `slow_card`=0, the period is (V mod 8)+2 core cycles. Bits 10..3 of V are ignored, and raising `data_mode` switches to this divisor with no other input changing.
- R3: With `slow_card`=1, the period is V+2 core cycles whatever the value of `data_mode`.
- R4: For a period of D core cycles, `card_clk` stays high for ceil(D/2) cycles and low for floor(D/2) cycles, in that order within each period.
- R5: `rise_stb` is high for exactly one core cycle per period, namely the first cycle in which `card_clk` is high.
- R6: `fall_stb` is high for exactly one core cycle per period, namely the first cycle in which `card_clk` is low.
- R7: The divider value, `data_mode` and `slow_card` are sampled only at the edge that starts a high phase. A change made during a period leaves that period's high and low lengths unchanged, and the new values apply from the next period on.
- R8: While `rst_n` is low, `card_clk`, `rise_stb` and `fall_stb` are 0. The first core clock edge after reset is released starts a high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_value | input | 11 | Software divider value (divisor minus two) |
| slow_card | input | 1 | Forces the full 11-bit divisor in all modes |
| data_mode | input | 1 | 1 while the controller is in data mode |
| card_clk | output | 1 | Divided card clock |
| rise_stb | output | 1 | One-cycle strobe in the first high cycle of card_clk |
| fall_stb | output | 1 | One-cycle strobe in the first low cycle of card_clk |

## Verification
The outputs are registered, so each output is due one core cycle after the edge that decides it. The strobe is visible in the same cycle as the `card_clk` level it marks. The bench changes inputs and samples outputs only at falling clock edges, so each sample shows the state after the preceding rising edge.

An input change made right after a rise shows up no earlier than the next rise, a full period later. For that reason each measurement first waits for a rise strictly after the change. It then counts high samples up to the fall and low samples up to the following rise. Those counts are compared with the ceil and floor halves of the divisor, which the bench computes from the value, the mode and the slow-card bit.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } sdclk_phase_e;

endpackage

// File: rtl/sdclk_div_select.sv
module sdclk_div_select #(
    parameter int DIV_W     = 11,
    parameter int DATA_BITS = 3,
    parameter int TOT_W     = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_value,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic [TOT_W-1:0] sel_div
);

    localparam logic [DIV_W-1:0] DATA_MASK = DIV_W'((1 << DATA_BITS) - 1);

    logic             use_full;
    logic [DIV_W-1:0] chosen;

    always_comb begin
        use_full = slow_card || !data_mode;
        chosen   = use_full ? div_value : (div_value & DATA_MASK);
        sel_div  = {1'b0, chosen} + TOT_W'(2);
    end

endmodule

// File: rtl/sdclk_phase_fsm.sv
module sdclk_phase_fsm
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 11,
    parameter int TOT_W = DIV_W + 1,
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOT_W-1:0] sel_div,
    output logic             card_clk,
    output logic             rise_stb,
    output logic             fall_stb
);

    sdclk_phase_e     state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [TOT_W-1:0] div_q, div_n;
    logic [TOT_W-1:0] hi_len, lo_len;

    always_comb begin
        hi_len = (sel_div + TOT_W'(1)) >> 1;
        lo_len = div_q >> 1;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        div_n   = div_q;
        unique case (state_q)
            PH_LOW: begin
                if (cnt_q == '0) begin
                    state_n = PH_HIGH;
                    div_n   = sel_div;
                    cnt_n   = CNT_W'(hi_len - TOT_W'(1));
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    state_n = PH_LOW;
                    cnt_n   = CNT_W'(lo_len - TOT_W'(1));
                end else begin
                    cnt_n = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
            div_q   <= TOT_W'(2);
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            div_q   <= div_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_clk <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            card_clk <= (state_n == PH_HIGH);
            rise_stb <= (state_q == PH_LOW)  && (state_n == PH_HIGH);
            fall_stb <= (state_q == PH_HIGH) && (state_n == PH_LOW);
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)); // R5
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (card_clk && !$past(card_clk))); // R5
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb); // R5
    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!card_clk && $past(card_clk))); // R6
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH || cnt_q != '0) |=> $stable(div_q)); // R7
    AST_MIN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        div_q >= TOT_W'(2)); // R1

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
    parameter int DIV_W     = 11,
    parameter int DATA_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_value,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic             card_clk,
    output logic             rise_stb,
    output logic             fall_stb
);

    localparam int TOT_W    = DIV_W + 1;
    localparam int CNT_W    = DIV_W;
    localparam int DATA_MAX = (1 << DATA_BITS) + 1;

    logic [TOT_W-1:0] sel_div;

    sdclk_div_select #(
        .DIV_W     (DIV_W),
        .DATA_BITS (DATA_BITS),
        .TOT_W     (TOT_W)
    ) u_sel (
        .div_value (div_value),
        .slow_card (slow_card),
        .data_mode (data_mode),
        .sel_div   (sel_div)
    );

    sdclk_phase_fsm #(
        .DIV_W (DIV_W),
        .TOT_W (TOT_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_div  (sel_div),
        .card_clk (card_clk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_mode && !slow_card) |-> (sel_div <= TOT_W'(DATA_MAX))); // R2
    AST_FULL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_card || !data_mode) |-> (sel_div == {1'b0, div_value} + TOT_W'(2))); // R3

endmodule

// File: tb/sim_sdclk_gen.sv
module sim_sdclk_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] div_value = 11'd0;
    logic        slow_card = 1'b0;
    logic        data_mode = 1'b0;
    logic        card_clk, rise_stb, fall_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    sdclk_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_value (div_value),
        .slow_card (slow_card),
        .data_mode (data_mode),
        .card_clk  (card_clk),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input int v, input bit slow, input bit mode);
        if (slow || !mode) return v + 2;
        return (v % 8) + 2;
    endfunction

    // Measure the next full period; optionally change inputs one cycle into it.
    task automatic measure(input string req, input int d,
                           input bit chg, input int nv, input bit ns, input bit nm);
        int hi = 0;
        int lo = 0;
        int guard = 0;
        @(negedge clk);
        while (!rise_stb && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk({req, " rise with high level R5"}, int'(card_clk), 1);
        while (card_clk && hi < 5000) begin
            if (hi > 0) chk({req, " rise single R5"}, int'(rise_stb), 0);
            hi++;
            if (hi == 1 && chg) begin
                div_value = 11'(nv);
                slow_card = ns;
                data_mode = nm;
            end
            @(negedge clk);
        end
        chk({req, " fall strobe R6"}, int'(fall_stb), 1);
        while (!rise_stb && lo < 5000) begin
            if (lo > 0) chk({req, " fall single R6"}, int'(fall_stb), 0);
            lo++;
            @(negedge clk);
        end
        chk({req, " high length R4"}, hi, (d + 1) / 2);
        chk({req, " low length R4"}, lo, d / 2);
        chk({req, " period"}, hi + lo, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int vals[6];
        // R8 reset state
        repeat (3) @(negedge clk);
        chk("R8 card_clk in reset", int'(card_clk), 0);
        chk("R8 rise_stb in reset", int'(rise_stb), 0);
        chk("R8 fall_stb in reset", int'(fall_stb), 0);
        div_value = 11'd3;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 first edge rises", int'(card_clk), 1);
        chk("R8 first rise strobe", int'(rise_stb), 1);

        // R1 identification-mode sweep
        for (int v = 0; v < 16; v++) begin
            div_value = 11'(v);
            measure("R1 ident", exp_div(v, 0, 0), 0, 0, 0, 0);
        end
        vals = '{507, 100, 255, 1000, 2047, 31};
        for (int i = 0; i < 6; i++) begin
            div_value = 11'(vals[i]);
            measure("R1 ident large", exp_div(vals[i], 0, 0), 0, 0, 0, 0);
        end

        // R2 data mode: low three bits only
        data_mode = 1'b1;
        for (int v = 0; v < 8; v++) begin
            div_value = 11'(v);
            measure("R2 data", exp_div(v, 0, 1), 0, 0, 0, 0);
        end
        for (int i = 0; i < 6; i++) begin
            div_value = 11'(vals[i]);
            measure("R2 data upper bits ignored", exp_div(vals[i], 0, 1), 0, 0, 0, 0);
        end
        // R2 automatic switch on mode change alone
        data_mode = 1'b0;
        div_value = 11'd507;
        measure("R2 before switch", 509, 0, 0, 0, 0);
        data_mode = 1'b1;
        measure("R2 after switch", 5, 0, 0, 0, 0);

        // R3 slow card forces full divisor
        slow_card = 1'b1;
        vals = '{13, 507, 8, 2047, 0, 9};
        for (int i = 0; i < 6; i++) begin
            div_value = 11'(vals[i]);
            data_mode = i[0];
            measure("R3 slow", exp_div(vals[i], 1, i[0]), 0, 0, 0, 0);
        end

        // R7 change mid-period keeps the running period
        slow_card = 1'b0;
        data_mode = 1'b0;
        div_value = 11'd9;
        measure("R7 setup", 11, 0, 0, 0, 0);
        measure("R7 old period kept", 11, 1, 0, 0, 0);
        measure("R7 new period", 2, 0, 0, 0, 0);
        measure("R7 mode change kept", 2, 1, 12, 0, 1);
        measure("R7 mode change applied", 6, 1, 12, 1, 1);
        measure("R7 slow change applied", 14, 0, 0, 0, 0);

        finish_run();
    end

endmodule